// File: doc/BRIEF.md
# Stochastic Channel Bit-Stream Generator

This block turns one quantised channel log-likelihood ratio (LLR) into a stochastic bit-stream. The density of ones in the stream equals the probability that the received bit is a one. The probability comes from a logistic lookup table. A 10-bit linear feedback shift register (LFSR) supplies one random word per output bit. A comparator emits a one whenever the random word is below the looked-up probability. Before the lookup, the LLR can optionally be multiplied by a programmable factor, which stands for the product of the damping constant and the noise density. A factor of 0.5 is the usual setting. The stream length is a power of two, from 1 to 1024 bits.

The LLR enters through a valid/ready handshake. `llr_ready` is high only while the block is idle, and the LLR is taken on the first cycle in which `llr_valid` and `llr_ready` are both high. The bits leave through a second valid/ready handshake. A bit is consumed only on a cycle in which `bit_valid` and `bit_ready` are both high. While `bit_ready` is low, the bit, the last marker and the random state all hold. Each LLR produces exactly one stream, and `done` pulses once when that stream is complete.

Top module: `sbg_stream_gen`

## Requirements
- R1: After reset, `llr_ready` is 1, while `bit_valid` and `done` are 0.
- R2: With scaling off, the probability for a 6-bit two's-complement LLR code c, which is the value c/4, is round(1024·e^(c/4)/(e^(c/4)+1)) for -28 < c < 28.
- R3: Each output bit is 1 exactly when the current LFSR word, read as unsigned, is less than the probability. The LFSR starts at 1 after reset. Its next state is {q[8:0], q[9]^q[6]}, and it advances only when a bit is consumed.
- R4: An LLR code of 28 or above gives a probability of 1024, so every bit is 1. A code of -28 or below gives 0, so every bit is 0.
- R5: When `scale_en` is 1, the code used for the lookup is floor(c·s/8), where s is the unsigned `scale_q` (value s/8). This result is clamped to the range -32..31.
- R6: A stream holds 2^m bits, where m is `len_log2` clamped to at most 10. `bit_last` is 1 on the final bit only.
- R7: `done` is high for exactly one cycle, in the cycle after the final bit is consumed. In that same cycle, `llr_ready` is 1 again.
- R8: While `bit_valid` is 1 and `bit_ready` is 0, `bit_data` and `bit_last` hold their values into the next cycle.
- R9: While a stream is running, `llr_ready` is 0, and any `llr_valid` or `llr_data` has no effect on the running stream.
- R10: A `seed_load` pulse while idle loads `seed` into the LFSR, and a seed of 0 loads as 1. A `seed_load` pulse while a stream is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| llr_valid | input | 1 | LLR offered |
| llr_ready | output | 1 | Block idle, LLR will be taken |
| llr_data | input | 6 | Signed LLR code, 2 fraction bits |
| scale_en | input | 1 | Apply the scaling factor |
| scale_q | input | 4 | Unsigned scaling factor, 3 fraction bits |
| len_log2 | input | 4 | Log2 of the stream length, sampled on acceptance |
| seed_load | input | 1 | Load the LFSR seed (idle only) |
| seed | input | 10 | LFSR seed value |
| bit_valid | output | 1 | Stream bit available |
| bit_ready | input | 1 | Consumer takes the bit |
| bit_data | output | 1 | Stochastic bit |
| bit_last | output | 1 | Final bit of the stream |
| done | output | 1 | One-cycle pulse after the final bit |

## Verification
The LLR is scaled, looked up and registered on the acceptance edge, so the first bit is valid in the cycle that follows. Each later bit is due one cycle after the bit before it is consumed, and `done` is due one cycle after the last bit is consumed. The bench drives every input on the falling edge and samples the outputs on the next falling edge, once per handshake. It compares each bit with its own LFSR model and a table it computes from the logistic formula. Stall cycles are checked by comparing each held bit with the value sampled one cycle earlier.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sbg_state_e;

  // Logistic probability scaled to 2^pw, saturated outside +/- sat codes.
  function automatic int sig_entry(input int code, input int frac,
                                   input int pw, input int sat);
    real l;
    real p;
    int  full;
    full = 1 << pw;
    if (code <= -sat) return 0;
    if (code >= sat) return full;
    l = real'(code) / real'(1 << frac);
    p = $exp(l) / ($exp(l) + 1.0);
    return $rtoi(p * real'(full) + 0.5);
  endfunction

endpackage

// File: rtl/sbg_scaler.sv
module sbg_scaler #(
  parameter int LLR_W   = 6,
  parameter int SC_W    = 4,
  parameter int SC_FRAC = 3
) (
  input  logic signed [LLR_W-1:0] llr,
  input  logic                    en,
  input  logic        [SC_W-1:0]  scale,
  output logic signed [LLR_W-1:0] llr_out
);
  localparam int PROD_W = LLR_W + SC_W + 1;
  localparam logic signed [PROD_W-1:0] MAXV = PROD_W'((1 << (LLR_W-1)) - 1);
  localparam logic signed [PROD_W-1:0] MINV = -PROD_W'(1 << (LLR_W-1));

  logic signed [PROD_W-1:0] llr_ext;
  logic signed [PROD_W-1:0] scale_ext;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;

  always_comb begin
    llr_ext   = PROD_W'(llr);
    scale_ext = $signed(PROD_W'(scale));
    prod      = llr_ext * scale_ext;
    shifted   = prod >>> SC_FRAC;
    if (!en)
      llr_out = llr;
    else if (shifted > MAXV)
      llr_out = MAXV[LLR_W-1:0];
    else if (shifted < MINV)
      llr_out = MINV[LLR_W-1:0];
    else
      llr_out = shifted[LLR_W-1:0];
  end
endmodule

// File: rtl/sbg_prob_lut.sv
module sbg_prob_lut #(
  parameter int LLR_W    = 6,
  parameter int FRAC     = 2,
  parameter int P_W      = 10,
  parameter int SAT_CODE = 28
) (
  input  logic signed [LLR_W-1:0] addr,
  output logic        [P_W:0]     prob
);
  localparam int DEPTH = 1 << LLR_W;
  localparam int HALF  = DEPTH / 2;
  localparam int PW1   = P_W + 1;

  logic [P_W:0]     tbl [DEPTH];
  logic [LLR_W-1:0] idx;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    localparam int CODE = gi - HALF;
    assign tbl[gi] = PW1'(sbg_pkg::sig_entry(CODE, FRAC, P_W, SAT_CODE));
  end

  // Offset-binary index: flipping the sign bit maps -HALF..HALF-1 to 0..DEPTH-1.
  assign idx  = {~addr[LLR_W-1], addr[LLR_W-2:0]};
  assign prob = tbl[idx];
endmodule

// File: rtl/sbg_lfsr.sv
module sbg_lfsr #(
  parameter int         W        = 10,
  parameter logic [W-1:0] TAP_MASK = 10'h240,
  parameter logic [W-1:0] INIT     = 10'h001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         adv,
  output logic [W-1:0] q
);
  logic         fb;
  logic [W-1:0] seed_fix;

  assign fb       = ^(q & TAP_MASK);
  assign seed_fix = (seed == '0) ? W'(1) : seed;

  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= INIT;
    else if (load)
      q <= seed_fix;
    else if (adv)
      q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/sbg_stream_gen.sv
module sbg_stream_gen #(
  parameter int LLR_W    = 6,
  parameter int LLR_FRAC = 2,
  parameter int SC_W     = 4,
  parameter int SC_FRAC  = 3,
  parameter int RND_W    = 10,
  parameter int MAX_LOG  = 10,
  parameter int LOG_W    = 4,
  parameter int SAT_CODE = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             llr_valid,
  output logic             llr_ready,
  input  logic [LLR_W-1:0] llr_data,
  input  logic             scale_en,
  input  logic [SC_W-1:0]  scale_q,
  input  logic [LOG_W-1:0] len_log2,
  input  logic             seed_load,
  input  logic [RND_W-1:0] seed,
  output logic             bit_valid,
  input  logic             bit_ready,
  output logic             bit_data,
  output logic             bit_last,
  output logic             done
);
  import sbg_pkg::*;

  localparam int CNT_W = MAX_LOG;
  localparam logic [LOG_W-1:0] LOG_CAP = LOG_W'(MAX_LOG);

  sbg_state_e          state;
  logic signed [LLR_W-1:0] llr_scaled;
  logic [RND_W:0]      lut_prob;
  logic [RND_W:0]      prob_q;
  logic [RND_W-1:0]    lfsr_q;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    last_idx;
  logic [CNT_W-1:0]    len_m1;
  logic [CNT_W:0]      span;
  logic [LOG_W-1:0]    eff_log;
  logic                done_q;
  logic                accept;
  logic                consume;

  sbg_scaler #(.LLR_W(LLR_W), .SC_W(SC_W), .SC_FRAC(SC_FRAC)) u_scaler (
    .llr    ($signed(llr_data)),
    .en     (scale_en),
    .scale  (scale_q),
    .llr_out(llr_scaled)
  );

  sbg_prob_lut #(.LLR_W(LLR_W), .FRAC(LLR_FRAC), .P_W(RND_W),
                 .SAT_CODE(SAT_CODE)) u_lut (
    .addr(llr_scaled),
    .prob(lut_prob)
  );

  sbg_lfsr #(.W(RND_W)) u_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (seed_load && (state == ST_IDLE)),
    .seed (seed),
    .adv  (consume),
    .q    (lfsr_q)
  );

  always_comb begin
    eff_log = (len_log2 > LOG_CAP) ? LOG_CAP : len_log2;
    span    = (CNT_W+1)'(1) << eff_log;
    len_m1  = CNT_W'(span - 1'b1);
  end

  assign llr_ready = (state == ST_IDLE);
  assign accept    = llr_valid && llr_ready;
  assign bit_valid = (state == ST_RUN);
  assign consume   = bit_valid && bit_ready;
  assign bit_data  = bit_valid && ({1'b0, lfsr_q} < prob_q);
  assign bit_last  = bit_valid && (cnt == last_idx);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      prob_q   <= '0;
      cnt      <= '0;
      last_idx <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            prob_q   <= lut_prob;
            cnt      <= '0;
            last_idx <= len_m1;
            state    <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (consume) begin
            if (cnt == last_idx) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbg_stream_gen_chk.sv
module sbg_stream_gen_chk #(
  parameter int RND_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             llr_valid,
  input logic             llr_ready,
  input logic             bit_valid,
  input logic             bit_ready,
  input logic             bit_data,
  input logic             bit_last,
  input logic             done,
  input logic [RND_W-1:0] lfsr_q
);
  a_r8_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && !bit_ready |=> bit_valid && $stable(bit_data) && $stable(bit_last));

  a_r3_lfsr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && !bit_ready |=> $stable(lfsr_q));

  a_r3_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> !llr_ready);

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && bit_ready && bit_last |=> done && llr_ready);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    llr_valid && llr_ready |=> bit_valid);
endmodule

bind sbg_stream_gen sbg_stream_gen_chk #(.RND_W(RND_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .llr_valid(llr_valid),
  .llr_ready(llr_ready),
  .bit_valid(bit_valid),
  .bit_ready(bit_ready),
  .bit_data (bit_data),
  .bit_last (bit_last),
  .done     (done),
  .lfsr_q   (lfsr_q)
);

// File: tb/sbg_stream_gen_bench.sv
`timescale 1ns/1ps
module sbg_stream_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       llr_valid = 1'b0;
  logic       llr_ready;
  logic [5:0] llr_data = '0;
  logic       scale_en = 1'b0;
  logic [3:0] scale_q = '0;
  logic [3:0] len_log2 = '0;
  logic       seed_load = 1'b0;
  logic [9:0] seed = '0;
  logic       bit_valid;
  logic       bit_ready = 1'b0;
  logic       bit_data;
  logic       bit_last;
  logic       done;

  int   tests = 0;
  int   fails = 0;
  bit   finished = 1'b0;
  logic [9:0] m_lfsr = 10'h001;
  int   last_ones = 0;

  always #2.5 clk = ~clk;

  sbg_stream_gen u_sbg_stream_gen (
    .clk(clk), .rst_n(rst_n), .llr_valid(llr_valid), .llr_ready(llr_ready),
    .llr_data(llr_data), .scale_en(scale_en), .scale_q(scale_q),
    .len_log2(len_log2), .seed_load(seed_load), .seed(seed),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_data(bit_data),
    .bit_last(bit_last), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_prob(input int code, input bit sen, input int sc);
    int  l;
    real x;
    l = code;
    if (sen) begin
      l = $rtoi($floor(real'(code * sc) / 8.0));
      if (l > 31) l = 31;
      if (l < -32) l = -32;
    end
    if (l <= -28) return 0;
    if (l >= 28) return 1024;
    x = real'(l) / 4.0;
    return $rtoi(1024.0 / (1.0 + $exp(-x)) + 0.5);
  endfunction

  function automatic logic [9:0] step(input logic [9:0] q);
    return {q[8:0], q[9] ^ q[6]};
  endfunction

  task automatic load_seed(input logic [9:0] s);
    @(negedge clk);
    seed_load = 1'b1;
    seed = s;
    @(negedge clk);
    seed_load = 1'b0;
    m_lfsr = (s == 10'd0) ? 10'd1 : s;
  endtask

  task automatic run_stream(input int code, input bit sen, input int sc,
                            input int lg, input bit stall, input bit poke,
                            input string tag);
    int n;
    int p;
    int got = 0;
    int bad_bits = 0;
    int bad_last = 0;
    int bad_hold = 0;
    int bad_busy = 0;
    int ones = 0;
    int k = 0;
    bit prev_rdy = 1'b1;
    bit prev_bit = 1'b0;
    bit rdy;
    bit expb;
    n = 1 << ((lg > 10) ? 10 : lg);
    p = exp_prob(code, sen, sc);
    @(negedge clk);
    chk(llr_ready == 1'b1, "R7", "ready before stream", int'(llr_ready), 1);
    llr_valid = 1'b1;
    llr_data = 6'(code);
    scale_en = sen;
    scale_q = 4'(sc);
    len_log2 = 4'(lg);
    bit_ready = 1'b0;
    @(negedge clk);
    llr_valid = 1'b0;
    while (got < n) begin
      if (poke) begin
        llr_valid = 1'b1;
        llr_data = 6'(-code - 1);
        seed_load = 1'b1;
        seed = 10'h155;
        if (llr_ready !== 1'b0) bad_busy++;
      end
      expb = ({1'b0, m_lfsr} < p);
      if (bit_valid !== 1'b1 || bit_data !== expb) bad_bits++;
      if (bit_last !== (got == n - 1)) bad_last++;
      if (!prev_rdy && bit_data !== prev_bit) bad_hold++;
      rdy = stall ? (k % 3 != 2) : 1'b1;
      bit_ready = rdy;
      prev_rdy = rdy;
      prev_bit = bit_data;
      k++;
      @(negedge clk);
      if (rdy) begin
        if (expb) ones++;
        m_lfsr = step(m_lfsr);
        got++;
      end
    end
    llr_valid = 1'b0;
    seed_load = 1'b0;
    bit_ready = 1'b0;
    last_ones = ones;
    chk(bad_bits == 0, tag, $sformatf("bit mismatches code %0d", code), bad_bits, 0);
    chk(bad_last == 0, "R6", "last marker errors", bad_last, 0);
    chk(done == 1'b1 && bit_valid == 1'b0 && llr_ready == 1'b1, "R7",
        "done/idle after last", int'({done, bit_valid, llr_ready}), 5);
    if (stall) chk(bad_hold == 0, "R8", "held bit changed", bad_hold, 0);
    if (poke) chk(bad_busy == 0, "R9", "ready during stream", bad_busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done width", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(llr_ready == 1'b1 && bit_valid == 1'b0 && done == 1'b0, "R1",
        "reset outputs", int'({llr_ready, bit_valid, done}), 4);
    rst_n = 1'b1;

    run_stream(3, 1'b0, 0, 4, 1'b0, 1'b0, "R3");
    load_seed(10'd0);
    run_stream(-5, 1'b0, 0, 4, 1'b0, 1'b0, "R10");
    load_seed(10'h3A7);
    run_stream(-5, 1'b0, 0, 4, 1'b0, 1'b0, "R10");

    for (int c = -32; c < 32; c++) run_stream(c, 1'b0, 0, 4, 1'b0, 1'b0, "R2");
    for (int c = -32; c < 32; c++) run_stream(c, 1'b1, 4, 3, 1'b0, 1'b0, "R5");
    for (int c = -32; c < 32; c += 3) run_stream(c, 1'b1, 15, 2, 1'b0, 1'b0, "R5");

    run_stream(28, 1'b0, 0, 10, 1'b0, 1'b0, "R4");
    chk(last_ones == 1024, "R4", "ones at +28", last_ones, 1024);
    run_stream(31, 1'b0, 0, 8, 1'b0, 1'b0, "R4");
    chk(last_ones == 256, "R4", "ones at +31", last_ones, 256);
    run_stream(-28, 1'b0, 0, 10, 1'b0, 1'b0, "R4");
    chk(last_ones == 0, "R4", "ones at -28", last_ones, 0);
    run_stream(-32, 1'b0, 0, 8, 1'b0, 1'b0, "R4");
    chk(last_ones == 0, "R4", "ones at -32", last_ones, 0);

    run_stream(5, 1'b0, 0, 15, 1'b0, 1'b0, "R6");
    run_stream(5, 1'b0, 0, 0, 1'b0, 1'b0, "R6");

    for (int c = -12; c <= 12; c += 4) run_stream(c, 1'b0, 0, 5, 1'b1, 1'b0, "R8");

    run_stream(-3, 1'b0, 0, 4, 1'b0, 1'b1, "R9");
    run_stream(7, 1'b0, 0, 4, 1'b0, 1'b0, "R10");

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule